// File: doc/BRIEF.md
# Priority Interrupt Acceptance Unit

This block sits next to a processor's sequencer and decides whether, and which, interrupt is taken at the end of each instruction. It watches eight maskable request lines and one non-maskable line. It looks at them only in the single cycle in which the sequencer raises an instruction-boundary strobe. When it accepts a source, it pulls an active-low acknowledge for one clock and, in that same clock, presents a 16-bit restart address. The sequencer loads that address into its program counter.

Software controls acceptance with enable and disable pulses that drive an interrupt-enable flag, and with a return pulse issued at the end of each service routine. A mode bit picks one of two disciplines. In sequential handling, nothing is taken while any routine is in service. In nested handling, only a strictly higher level may preempt the routine in service. A small in-service stack records the level of each active routine, so that a return restores the level that was active before it.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset, ack_no is 1, vector_o is 0, the enable flag is clear, the mode is sequential and the in-service stack is empty.
- R2: An ei_i pulse sets the enable flag and a di_i pulse clears it. When both are high in the same cycle, di_i wins.
- R3: Requests are taken only on a cycle with boundary_i high. On acceptance, ack_no is 0 for exactly the next cycle and vector_o holds the restart address in that cycle. In every other cycle vector_o is 0. A strobe that falls in an acknowledge cycle is not taken.
- R4: A maskable request is taken only while the enable flag is set. Every acceptance clears the flag.
- R5: nmi_i outranks all maskable lines, ignores the enable flag, and produces vector 0x0024.
- R6: Among maskable lines, irq_i[7] has the highest priority and irq_i[0] the lowest. Line k produces vector k*8, so line 5 gives 0x0028 and line 0 gives 0x0000.
- R7: In sequential mode, no source, including nmi_i, is taken while the stack is non-empty. Each ret_i pulse pops one entry and sets the enable flag.
- R8: In nested mode, a source is taken only if its level is strictly above the level on top of the stack. Maskable line k has level k+1 and nmi_i has level 9. Maskable lines still need the enable flag.
- R9: The stack holds up to 8 levels. A return restores the previous top level. While the stack is full, nothing is taken.
- R10: A mode_wr_i pulse loads mode_nest_i into the mode bit (1 selects nested). Reset returns the unit to sequential mode.
- R11: A boundary strobe in the same cycle as ret_i is not taken. The return still pops the stack and sets the enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | Maskable request lines, level sensitive |
| nmi_i | input | 1 | Non-maskable request, level sensitive |
| boundary_i | input | 1 | One-cycle instruction-boundary strobe |
| ei_i | input | 1 | Enable-flag set pulse |
| di_i | input | 1 | Enable-flag clear pulse |
| ret_i | input | 1 | End-of-service pulse |
| mode_wr_i | input | 1 | Mode bit load strobe |
| mode_nest_i | input | 1 | Mode value: 1 nested, 0 sequential |
| ack_no | output | 1 | Active-low acknowledge, one cycle |
| vector_o | output | 16 | Restart address, valid while ack_no is 0 |

## Verification
The assertions assume that the sequencer raises boundary_i for a single cycle per instruction. They also assume that ret_i is issued only to close a routine that was actually acknowledged, and that a serviced source lowers its request before the routine returns. The stimulus respects these limits. It drops each request line before the matching return pulse and spaces its strobes at least one cycle apart. The one exception is a deliberate two-cycle strobe, which exercises the rule that a strobe falling in an acknowledge cycle is not taken. Requests are changed only between strobes, so the expected vector for each strobe is fixed by the rules alone.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int VEC_W   = 16;
  localparam int VEC_STEP = 8;
  localparam logic [VEC_W-1:0] NMI_VEC = 16'h0024;

  function automatic logic [VEC_W-1:0] restart_vec(input int unsigned n);
    return VEC_W'(n * VEC_STEP);
  endfunction
endpackage

// File: rtl/irq_src_pick.sv
module irq_src_pick
  import irq_prio_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 4
) (
  input  logic [N_SRC-1:0] irq_i,
  input  logic             nmi_i,
  output logic             any_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    any_o = nmi_i | (|irq_i);
    lvl_o = '0;
    vec_o = '0;
    // ascending scan: the last hit is the highest index
    for (int i = 0; i < N_SRC; i++) begin
      if (irq_i[i]) begin
        lvl_o = LVL_W'(i + 1);
        vec_o = restart_vec(i);
      end
    end
    if (nmi_i) begin
      lvl_o = LVL_W'(N_SRC + 1);
      vec_o = NMI_VEC;
    end
  end
endmodule

// File: rtl/irq_isr_stack.sv
module irq_isr_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (push_i && !full_o)  cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty_o)  cnt_q <= cnt_q - 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && !full_o && cnt_q == CNT_W'(g)) mem_q[g] <= data_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CNT_W'(i + 1)) top_o = mem_q[i];
    end
  end

  a_r9_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r9_count_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r9_push_sets_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> (top_o == $past(data_i)));
  a_r9_pop_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_prio_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             nmi_i,
  input  logic             boundary_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             ret_i,
  input  logic             mode_wr_i,
  input  logic             mode_nest_i,
  output logic             ack_no,
  output logic [VEC_W-1:0] vector_o
);
  localparam int LVL_W = $clog2(N_SRC + 2);

  logic             ie_q, nest_q, ack_q;
  logic [VEC_W-1:0] vec_q;
  logic             pick_any;
  logic [LVL_W-1:0] pick_lvl, top_lvl;
  logic [VEC_W-1:0] pick_vec;
  logic             stk_empty, stk_full;
  logic             level_ok, accept, pop;

  irq_src_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_pick (
    .irq_i (irq_i & {N_SRC{ie_q}}),
    .nmi_i (nmi_i),
    .any_o (pick_any),
    .lvl_o (pick_lvl),
    .vec_o (pick_vec)
  );

  irq_isr_stack #(.DEPTH(DEPTH), .W(LVL_W)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (accept),
    .pop_i   (pop),
    .data_i  (pick_lvl),
    .top_o   (top_lvl),
    .empty_o (stk_empty),
    .full_o  (stk_full)
  );

  always_comb begin
    level_ok = nest_q ? (pick_lvl > top_lvl) : stk_empty;
    accept   = boundary_i && !ret_i && !ack_q && pick_any && !stk_full && level_ok;
    pop      = ret_i && !stk_empty;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= 1'b0;
      nest_q <= 1'b0;
      ack_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (accept)     ie_q <= 1'b0;
      else if (ret_i) ie_q <= 1'b1;
      else if (di_i)  ie_q <= 1'b0;
      else if (ei_i)  ie_q <= 1'b1;
      if (mode_wr_i) nest_q <= mode_nest_i;
      ack_q <= accept;
      vec_q <= accept ? pick_vec : '0;
    end
  end

  assign ack_no   = ~ack_q;
  assign vector_o = vec_q;

  a_r3_ack_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no |=> ack_no);
  a_r3_ack_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i == 1'b0 |=> ack_no);
  a_r3_vec_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_no |-> (vector_o == '0));
  a_r4_ack_clears_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no |-> !ie_q);
  a_r4_masked_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !ie_q && !nmi_i) |=> ack_no);
  a_r7_seq_one_at_a_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !nest_q && !stk_empty) |=> ack_no);
  a_r11_ret_blocks_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i |=> ack_no);
  a_r6_vec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_no && vector_o != NMI_VEC) |-> (vector_o[2:0] == 3'b000));
endmodule

// File: tb/test_irq_prio_unit.sv
`timescale 1ns/1ps
module test_irq_prio_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  irq_i = '0;
  logic        nmi_i = 1'b0, boundary_i = 1'b0, ei_i = 1'b0, di_i = 1'b0, ret_i = 1'b0;
  logic        mode_wr_i = 1'b0, mode_nest_i = 1'b0;
  logic        ack_no;
  logic [15:0] vector_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk_i = ~clk_i;

  irq_prio_unit i_irq_prio_unit (
    .clk_i, .rst_ni, .irq_i, .nmi_i, .boundary_i, .ei_i, .di_i, .ret_i,
    .mode_wr_i, .mode_nest_i, .ack_no, .vector_o
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: every acknowledge must match the next queued expectation
  always @(negedge clk_i) begin
    if (rst_ni && !ack_no) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected ack", vector_o, 16'hxxxx);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(vector_o == e, t, vector_o, e);
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic pulse_ei(); ei_i = 1; tick(); ei_i = 0; endtask
  task automatic pulse_di(); di_i = 1; tick(); di_i = 0; endtask
  task automatic pulse_ret(); ret_i = 1; tick(); ret_i = 0; endtask
  task automatic set_mode(input bit nest);
    mode_nest_i = nest; mode_wr_i = 1; tick(); mode_wr_i = 0;
  endtask

  task automatic strobe(input bit take, input logic [15:0] v, input string tag);
    boundary_i = 1;
    if (take) begin exp_q.push_back(v); tag_q.push_back(tag); end
    tick();
    boundary_i = 0;
    if (!take) begin
      @(negedge clk_i);
      check(ack_no == 1'b1, tag, 16'(ack_no), 16'h1);
    end
    tick();
  endtask

  task automatic do_reset();
    rst_ni = 0; tick(2); rst_ni = 1; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk_i);
    check(ack_no == 1'b1, "R1 reset ack high", 16'(ack_no), 16'h1);
    check(vector_o == 16'h0, "R1 reset vector zero", vector_o, 16'h0);
    tick();

    irq_i = 8'h20;
    strobe(0, 0, "R4 masked while enable clear");
    pulse_ei();
    tick(3);
    @(negedge clk_i);
    check(ack_no == 1'b1, "R3 no ack without strobe", 16'(ack_no), 16'h1);
    tick();
    strobe(1, 16'h0028, "R6 line 5 vector");

    pulse_ei();
    irq_i = 8'hA0;
    strobe(0, 0, "R7 sequential blocks while in service");
    irq_i = 8'h44;
    pulse_ret();
    strobe(1, 16'h0030, "R6 line 6 over line 2");
    irq_i = 0;
    pulse_ret();

    ei_i = 1; di_i = 1; tick(); ei_i = 0; di_i = 0;
    irq_i = 8'h08;
    strobe(0, 0, "R2 disable wins over enable");
    pulse_ei();
    strobe(1, 16'h0018, "R2 enable allows line 3");
    nmi_i = 1;
    strobe(0, 0, "R7 nmi waits in sequential mode");
    irq_i = 0;
    pulse_ret();
    strobe(1, 16'h0024, "R5 nmi after return");
    nmi_i = 0;
    pulse_ret();

    pulse_di();
    nmi_i = 1; irq_i = 8'h80;
    strobe(1, 16'h0024, "R5 nmi beats line 7 with enable clear");
    nmi_i = 0; irq_i = 0;
    pulse_ret();

    set_mode(1);
    irq_i = 8'h04;
    strobe(1, 16'h0010, "R10 nested mode line 2");
    pulse_ei();
    irq_i = 8'h06;
    strobe(0, 0, "R8 equal and lower wait");
    irq_i = 8'h16;
    strobe(1, 16'h0020, "R8 line 4 preempts");
    pulse_ei();
    nmi_i = 1;
    strobe(1, 16'h0024, "R8 nmi preempts");
    nmi_i = 0; irq_i = 8'h06;
    pulse_ret();
    irq_i = 8'h0E;
    strobe(0, 0, "R9 restored level blocks line 3");
    irq_i = 8'h2E;
    strobe(1, 16'h0028, "R9 line 5 above restored level");
    irq_i = 0;
    pulse_ret(); pulse_ret(); pulse_ret();

    irq_i = 8'h01;
    strobe(1, 16'h0000, "R6 line 0 vector zero");
    pulse_ei();
    irq_i = 8'h81;
    boundary_i = 1; ret_i = 1; tick(); boundary_i = 0; ret_i = 0;
    @(negedge clk_i);
    check(ack_no == 1'b1, "R11 strobe with return not taken", 16'(ack_no), 16'h1);
    tick();
    strobe(1, 16'h0038, "R11 return popped and re-enabled");
    irq_i = 0;
    pulse_ret();

    for (int k = 0; k < 8; k++) begin
      irq_i[k] = 1'b1;
      pulse_ei();
      strobe(1, 16'(k * 8), "R9 fill stack");
    end
    nmi_i = 1;
    pulse_ei();
    strobe(0, 0, "R9 full stack blocks nmi");
    pulse_ret();
    strobe(1, 16'h0024, "R9 nmi after one pop");
    nmi_i = 0; irq_i = 0;
    for (int k = 0; k < 8; k++) pulse_ret();
    irq_i = 8'h01;
    strobe(1, 16'h0000, "R9 stack emptied by returns");
    irq_i = 0;
    pulse_ret();

    pulse_ei();
    irq_i = 8'h02;
    boundary_i = 1;
    exp_q.push_back(16'h0008); tag_q.push_back("R3 first of double strobe");
    tick();
    nmi_i = 1;
    tick();
    boundary_i = 0;
    @(negedge clk_i);
    check(ack_no == 1'b1, "R3 strobe in ack cycle not taken", 16'(ack_no), 16'h1);
    tick();
    strobe(1, 16'h0024, "R3 nmi on later strobe");
    nmi_i = 0; irq_i = 0;
    pulse_ret(); pulse_ret();

    do_reset();
    irq_i = 8'h04;
    strobe(0, 0, "R1 enable clear after reset");
    pulse_ei();
    strobe(1, 16'h0010, "R1 line 2 after enable");
    pulse_ei();
    irq_i = 8'h84;
    strobe(0, 0, "R10 reset restores sequential mode");
    irq_i = 0;
    pulse_ret();

    tick(2);
    check(exp_q.size() == 0, "R3 all expected acks seen", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule